// File: doc/BRIEF.md
# Per-Lane Output Squelch and Disable Controller

This block decides, for every receive and every transmit lane of a four-lane pluggable port, whether that lane's output driver may run. Each receive lane gets a loss-of-signal indication from its detector, and each transmit lane gets an indication that its electrical input has fallen below the amplitude threshold. Control register bits come in per lane: one that defeats automatic squelch, and one that forces the lane off. Automatic squelch is on by default. A squelch-defeat bit can turn it off per lane. A disable bit turns the lane off whatever the other inputs are.

Every input passes through its own qualification timer. A change is accepted only after the input has held its new level for a parameterised number of consecutive clock cycles, and each timer can use a different count for asserting and for deasserting. The block therefore meets any "within N" response window with a latency that is fixed and known.

For transmit lanes, a parameter selects how low amplitude is handled. The lane is either muted (its modulation is silenced while its emitter stays enabled) or turned fully off. A sticky per-lane low-amplitude flag is also produced for the interrupt logic. It stays set until a per-lane clear strobe arrives while the condition is gone.

Top module: `lane_gate_ctrl`

## Requirements
- R1: For receive lane i, a loss-of-signal input that stays high for RX_SQ_CYC consecutive cycles drives rx_en_o[i] low RX_SQ_CYC+1 cycles after it was first sampled, unless squelch is defeated for that lane. The lane comes back RX_SQ_CYC+1 cycles after the input has been low for that long.
- R2: With rx_sqd_i[i]=1, receive loss-of-signal has no effect on rx_en_o[i]. A change on a squelch-defeat bit (receive or transmit) takes effect SQD_CYC+1 cycles after it was first sampled.
- R3: rx_dis_i[i]=1 forces rx_en_o[i]=0 regardless of loss-of-signal and squelch-defeat. The forced state is applied and released RX_DIS_CYC+1 cycles after the bit changes.
- R4: A transmit low-amplitude input held for TX_SQ_CYC cycles gates that lane TX_SQ_CYC+1 cycles later. With TX_FULL_OFF=0 the gate raises tx_mute_o[i] and leaves tx_en_o[i]=1. With TX_FULL_OFF=1 the gate drops tx_en_o[i] and tx_mute_o stays 0.
- R5: With tx_sqd_i[i]=1, transmit low amplitude neither mutes nor disables lane i.
- R6: tx_dis_i[i]=1 forces tx_en_o[i]=0 and tx_mute_o[i]=0 regardless of squelch-defeat. It turns the lane off TX_OFF_CYC+1 cycles after being set and lets it back on TX_ON_CYC+1 cycles after being cleared.
- R7: txlos_flag_o[i] is set when low amplitude on lane i is qualified, whatever the squelch-defeat setting. It stays set after the input recovers. It clears one cycle after a txlos_clr_i[i] pulse only if the qualified condition has gone.
- R8: Lanes are independent: inputs of one lane never change another lane's outputs.
- R9: An input pulse shorter than its qualification count produces no change on any output.
- R10: After synchronous reset, every lane has rx_en_o=1, tx_en_o=1, tx_mute_o=0 and txlos_flag_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_los_i | input | LANES | Receive loss-of-signal per lane |
| tx_lowamp_i | input | LANES | Transmit input below amplitude threshold per lane |
| rx_sqd_i | input | LANES | Receive squelch-defeat register bits |
| tx_sqd_i | input | LANES | Transmit squelch-defeat register bits |
| rx_dis_i | input | LANES | Receive output disable register bits |
| tx_dis_i | input | LANES | Transmit disable register bits |
| txlos_clr_i | input | LANES | Per-lane clear strobe for the low-amplitude flag (read side effect) |
| rx_en_o | output | LANES | Receive output enable per lane |
| tx_en_o | output | LANES | Transmit emitter enable per lane |
| tx_mute_o | output | LANES | Transmit modulation mute per lane |
| txlos_flag_o | output | LANES | Sticky transmit low-amplitude flag per lane |

## Verification
The bench builds two copies with four lanes and short qualification counts of 2 to 6 cycles, one in mute mode and one in full-off mode. With counts this short it can sweep every combination of loss, squelch-defeat and disable on each lane in turn, and check the outputs of all other lanes for crosstalk. It can also step the exact edge at which each timer releases its change and compare that edge with the one computed from the count. The same short counts allow pulses one cycle shorter than a window to be applied, so the bench can confirm they are filtered out. They also allow the flag's sticky and clear behaviour to be tested with the condition both present and absent.

// File: rtl/lane_gate_pkg.sv
package lane_gate_pkg;

  typedef struct packed {
    logic los;   // qualified loss / low amplitude
    logic sqd;   // qualified squelch-defeat
    logic dis;   // qualified disable
  } lane_cond_t;

  function automatic logic squelch_req(input lane_cond_t c);
    return c.los && !c.sqd;
  endfunction

  function automatic logic lane_pass(input lane_cond_t c);
    return !c.dis && !squelch_req(c);
  endfunction

endpackage

// File: rtl/lg_qual_timer.sv
module lg_qual_timer #(
  parameter int ASSERT_CYC   = 4,
  parameter int DEASSERT_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic qual_o
);
  localparam int MAXC = (ASSERT_CYC > DEASSERT_CYC) ? ASSERT_CYC : DEASSERT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb lim = qual_o ? CW'(DEASSERT_CYC - 1) : CW'(ASSERT_CYC - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_o <= 1'b0;
      cnt    <= '0;
    end else if (raw_i == qual_o) begin
      cnt <= '0;
    end else if (cnt == lim) begin
      qual_o <= raw_i;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lg_rx_lane.sv
module lg_rx_lane
  import lane_gate_pkg::*;
#(
  parameter int RX_SQ_CYC  = 4,
  parameter int RX_DIS_CYC = 4,
  parameter int SQD_CYC    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic los_i,
  input  logic sqd_i,
  input  logic dis_i,
  output logic en_o
);
  lane_cond_t c;

  lg_qual_timer #(.ASSERT_CYC(RX_SQ_CYC), .DEASSERT_CYC(RX_SQ_CYC)) u_los (
    .clk(clk), .rst(rst), .raw_i(los_i), .qual_o(c.los));
  lg_qual_timer #(.ASSERT_CYC(SQD_CYC), .DEASSERT_CYC(SQD_CYC)) u_sqd (
    .clk(clk), .rst(rst), .raw_i(sqd_i), .qual_o(c.sqd));
  lg_qual_timer #(.ASSERT_CYC(RX_DIS_CYC), .DEASSERT_CYC(RX_DIS_CYC)) u_dis (
    .clk(clk), .rst(rst), .raw_i(dis_i), .qual_o(c.dis));

  always_ff @(posedge clk) begin
    if (rst) en_o <= 1'b1;
    else     en_o <= lane_pass(c);
  end
endmodule

// File: rtl/lg_tx_lane.sv
module lg_tx_lane
  import lane_gate_pkg::*;
#(
  parameter int TX_SQ_CYC   = 4,
  parameter int TX_OFF_CYC  = 4,
  parameter int TX_ON_CYC   = 4,
  parameter int SQD_CYC     = 4,
  parameter bit TX_FULL_OFF = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic lowamp_i,
  input  logic sqd_i,
  input  logic dis_i,
  input  logic clr_i,
  output logic en_o,
  output logic mute_o,
  output logic flag_o
);
  lane_cond_t c;
  logic en_nx, mute_nx;

  lg_qual_timer #(.ASSERT_CYC(TX_SQ_CYC), .DEASSERT_CYC(TX_SQ_CYC)) u_low (
    .clk(clk), .rst(rst), .raw_i(lowamp_i), .qual_o(c.los));
  lg_qual_timer #(.ASSERT_CYC(SQD_CYC), .DEASSERT_CYC(SQD_CYC)) u_sqd (
    .clk(clk), .rst(rst), .raw_i(sqd_i), .qual_o(c.sqd));
  lg_qual_timer #(.ASSERT_CYC(TX_OFF_CYC), .DEASSERT_CYC(TX_ON_CYC)) u_dis (
    .clk(clk), .rst(rst), .raw_i(dis_i), .qual_o(c.dis));

  generate
    if (TX_FULL_OFF) begin : g_full_off
      always_comb begin
        en_nx   = lane_pass(c);
        mute_nx = 1'b0;
      end
    end else begin : g_mute
      always_comb begin
        en_nx   = !c.dis;
        mute_nx = squelch_req(c) && !c.dis;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b1;
      mute_o <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      en_o   <= en_nx;
      mute_o <= mute_nx;
      flag_o <= c.los || (flag_o && !clr_i);
    end
  end
endmodule

// File: rtl/lane_gate_ctrl.sv
module lane_gate_ctrl #(
  parameter int LANES       = 4,
  parameter int RX_SQ_CYC   = 8000,
  parameter int TX_SQ_CYC   = 40000000,
  parameter int TX_OFF_CYC  = 10000000,
  parameter int TX_ON_CYC   = 40000000,
  parameter int RX_DIS_CYC  = 10000000,
  parameter int SQD_CYC     = 10000000,
  parameter bit TX_FULL_OFF = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] rx_los_i,
  input  logic [LANES-1:0] tx_lowamp_i,
  input  logic [LANES-1:0] rx_sqd_i,
  input  logic [LANES-1:0] tx_sqd_i,
  input  logic [LANES-1:0] rx_dis_i,
  input  logic [LANES-1:0] tx_dis_i,
  input  logic [LANES-1:0] txlos_clr_i,
  output logic [LANES-1:0] rx_en_o,
  output logic [LANES-1:0] tx_en_o,
  output logic [LANES-1:0] tx_mute_o,
  output logic [LANES-1:0] txlos_flag_o
);
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      lg_rx_lane #(
        .RX_SQ_CYC(RX_SQ_CYC), .RX_DIS_CYC(RX_DIS_CYC), .SQD_CYC(SQD_CYC)
      ) u_rx (
        .clk(clk), .rst(rst), .los_i(rx_los_i[i]), .sqd_i(rx_sqd_i[i]),
        .dis_i(rx_dis_i[i]), .en_o(rx_en_o[i]));

      lg_tx_lane #(
        .TX_SQ_CYC(TX_SQ_CYC), .TX_OFF_CYC(TX_OFF_CYC), .TX_ON_CYC(TX_ON_CYC),
        .SQD_CYC(SQD_CYC), .TX_FULL_OFF(TX_FULL_OFF)
      ) u_tx (
        .clk(clk), .rst(rst), .lowamp_i(tx_lowamp_i[i]), .sqd_i(tx_sqd_i[i]),
        .dis_i(tx_dis_i[i]), .clr_i(txlos_clr_i[i]), .en_o(tx_en_o[i]),
        .mute_o(tx_mute_o[i]), .flag_o(txlos_flag_o[i]));
    end
  endgenerate
endmodule

// File: rtl/lane_gate_chk.sv
module lane_gate_chk #(
  parameter int LANES       = 4,
  parameter int RX_SQ_CYC   = 4,
  parameter int TX_OFF_CYC  = 4,
  parameter int RX_DIS_CYC  = 4,
  parameter bit TX_FULL_OFF = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic [LANES-1:0] rx_los_i,
  input logic [LANES-1:0] rx_dis_i,
  input logic [LANES-1:0] tx_dis_i,
  input logic [LANES-1:0] txlos_clr_i,
  input logic [LANES-1:0] rx_en_o,
  input logic [LANES-1:0] tx_en_o,
  input logic [LANES-1:0] tx_mute_o,
  input logic [LANES-1:0] txlos_flag_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    logic [31:0] rxdis_hi, rxdis_lo, txdis_hi, los_lo;

    always_ff @(posedge clk) begin
      if (rst) begin
        rxdis_hi <= '0; rxdis_lo <= '0; txdis_hi <= '0; los_lo <= '0;
      end else begin
        rxdis_hi <= rx_dis_i[i]  ? ((rxdis_hi != '1) ? rxdis_hi + 1 : rxdis_hi) : '0;
        rxdis_lo <= !rx_dis_i[i] ? ((rxdis_lo != '1) ? rxdis_lo + 1 : rxdis_lo) : '0;
        txdis_hi <= tx_dis_i[i]  ? ((txdis_hi != '1) ? txdis_hi + 1 : txdis_hi) : '0;
        los_lo   <= !rx_los_i[i] ? ((los_lo != '1) ? los_lo + 1 : los_lo) : '0;
      end
    end

    a_r3_rx_dis_forces_off: assert property (@(posedge clk) disable iff (rst)
      (rxdis_hi > 32'(RX_DIS_CYC)) |-> !rx_en_o[i]);

    a_r1_rx_quiet_lane_on: assert property (@(posedge clk) disable iff (rst)
      (los_lo > 32'(RX_SQ_CYC) && rxdis_lo > 32'(RX_DIS_CYC)) |-> rx_en_o[i]);

    a_r6_tx_dis_forces_off: assert property (@(posedge clk) disable iff (rst)
      (txdis_hi > 32'(TX_OFF_CYC)) |-> (!tx_en_o[i] && !tx_mute_o[i]));

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (txlos_flag_o[i] && !txlos_clr_i[i]) |=> txlos_flag_o[i]);

    if (!TX_FULL_OFF) begin : g_mute_mode
      a_r4_mute_keeps_enable: assert property (@(posedge clk) disable iff (rst)
        tx_mute_o[i] |-> tx_en_o[i]);
    end
  end
endmodule

bind lane_gate_ctrl lane_gate_chk #(
  .LANES(LANES), .RX_SQ_CYC(RX_SQ_CYC), .TX_OFF_CYC(TX_OFF_CYC),
  .RX_DIS_CYC(RX_DIS_CYC), .TX_FULL_OFF(TX_FULL_OFF)
) u_chk (
  .clk(clk), .rst(rst), .rx_los_i(rx_los_i), .rx_dis_i(rx_dis_i),
  .tx_dis_i(tx_dis_i), .txlos_clr_i(txlos_clr_i), .rx_en_o(rx_en_o),
  .tx_en_o(tx_en_o), .tx_mute_o(tx_mute_o), .txlos_flag_o(txlos_flag_o)
);

// File: tb/sim_lane_gate_ctrl.sv
module sim_lane_gate_ctrl;
  localparam int CLK_P  = 10;
  localparam int L      = 4;
  localparam int RX_SQ  = 3;
  localparam int TX_SQ  = 5;
  localparam int TX_OFF = 2;
  localparam int TX_ON  = 6;
  localparam int RX_DIS = 4;
  localparam int SQD    = 3;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [L-1:0] rx_los = '0, tx_low = '0, rx_sqd = '0, tx_sqd = '0;
  logic [L-1:0] rx_dis = '0, tx_dis = '0, clr = '0;
  logic [L-1:0] rx_en0, tx_en0, mute0, flag0;
  logic [L-1:0] rx_en1, tx_en1, mute1, flag1;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lane_gate_ctrl #(.LANES(L), .RX_SQ_CYC(RX_SQ), .TX_SQ_CYC(TX_SQ), .TX_OFF_CYC(TX_OFF),
    .TX_ON_CYC(TX_ON), .RX_DIS_CYC(RX_DIS), .SQD_CYC(SQD), .TX_FULL_OFF(1'b0)) u0 (
    .clk(clk), .rst(rst), .rx_los_i(rx_los), .tx_lowamp_i(tx_low), .rx_sqd_i(rx_sqd),
    .tx_sqd_i(tx_sqd), .rx_dis_i(rx_dis), .tx_dis_i(tx_dis), .txlos_clr_i(clr),
    .rx_en_o(rx_en0), .tx_en_o(tx_en0), .tx_mute_o(mute0), .txlos_flag_o(flag0));

  lane_gate_ctrl #(.LANES(L), .RX_SQ_CYC(RX_SQ), .TX_SQ_CYC(TX_SQ), .TX_OFF_CYC(TX_OFF),
    .TX_ON_CYC(TX_ON), .RX_DIS_CYC(RX_DIS), .SQD_CYC(SQD), .TX_FULL_OFF(1'b1)) u1 (
    .clk(clk), .rst(rst), .rx_los_i(rx_los), .tx_lowamp_i(tx_low), .rx_sqd_i(rx_sqd),
    .tx_sqd_i(tx_sqd), .rx_dis_i(rx_dis), .tx_dis_i(tx_dis), .txlos_clr_i(clr),
    .rx_en_o(rx_en1), .tx_en_o(tx_en1), .tx_mute_o(mute1), .txlos_flag_o(flag1));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [L-1:0] e_rx, e_en0, e_mu0, e_en1, e_fl;
    logic los, sqd, dis;

    tick(3);
    rst = 1'b0;
    tick(1);
    // R10 reset state
    chk("R10 rx_en", {4'h0, rx_en0}, 8'h0F);
    chk("R10 tx_en", {tx_en1, tx_en0}, 8'hFF);
    chk("R10 mute", {mute1, mute0}, 8'h00);
    chk("R10 flag", {flag1, flag0}, 8'h00);

    // R1 R2 R3 R8: receive sweep over every lane and input combination
    for (int ln = 0; ln < L; ln++) begin
      for (int c = 0; c < 8; c++) begin
        los = c[0]; sqd = c[1]; dis = c[2];
        rx_los[ln] = los; rx_sqd[ln] = sqd; rx_dis[ln] = dis;
        tick(SETTLE);
        e_rx = '1;
        e_rx[ln] = !(dis || (los && !sqd));
        chk("R1/R2/R3/R8 rx sweep", {4'h0, rx_en0}, {4'h0, e_rx});
        chk("R8 rx sweep copy1", {4'h0, rx_en1}, {4'h0, e_rx});
        rx_los = '0; rx_sqd = '0; rx_dis = '0;
        tick(SETTLE);
      end
    end

    // R4 R5 R6 R7 R8: transmit sweep, both modes
    for (int ln = 0; ln < L; ln++) begin
      for (int c = 0; c < 8; c++) begin
        los = c[0]; sqd = c[1]; dis = c[2];
        tx_low[ln] = los; tx_sqd[ln] = sqd; tx_dis[ln] = dis;
        tick(SETTLE);
        e_en0 = '1; e_mu0 = '0; e_en1 = '1; e_fl = '0;
        e_en0[ln] = !dis;
        e_mu0[ln] = los && !sqd && !dis;
        e_en1[ln] = !(dis || (los && !sqd));
        e_fl[ln]  = los;
        chk("R4/R5/R6/R8 tx mute-mode en+mute", {tx_en0, mute0}, {e_en0, e_mu0});
        chk("R4/R5/R6/R8 tx off-mode en+mute", {tx_en1, mute1}, {e_en1, 4'h0});
        chk("R7 flag set", {flag1, flag0}, {e_fl, e_fl});
        tx_low = '0; tx_sqd = '0; tx_dis = '0;
        tick(SETTLE);
        chk("R7 flag sticky", {flag1, flag0}, {e_fl, e_fl});
        clr = '1; tick(1); clr = '0; tick(1);
        chk("R7 flag cleared", {flag1, flag0}, 8'h00);
      end
    end

    // R1 exact timing, lane 1
    rx_los[1] = 1'b1;
    tick(RX_SQ);     chk("R1 assert not early", {7'h0, rx_en0[1]}, 8'h01);
    tick(1);         chk("R1 assert on time", {7'h0, rx_en0[1]}, 8'h00);
    rx_los[1] = 1'b0;
    tick(RX_SQ);     chk("R1 release not early", {7'h0, rx_en0[1]}, 8'h00);
    tick(1);         chk("R1 release on time", {7'h0, rx_en0[1]}, 8'h01);

    // R2 squelch-defeat timing while lane 1 is squelched
    rx_los[1] = 1'b1; tick(SETTLE);
    rx_sqd[1] = 1'b1;
    tick(SQD);       chk("R2 sqd not early", {7'h0, rx_en0[1]}, 8'h00);
    tick(1);         chk("R2 sqd on time", {7'h0, rx_en0[1]}, 8'h01);
    rx_los = '0; rx_sqd = '0; tick(SETTLE);

    // R3 exact timing, lane 3
    rx_dis[3] = 1'b1;
    tick(RX_DIS);    chk("R3 off not early", {7'h0, rx_en0[3]}, 8'h01);
    tick(1);         chk("R3 off on time", {7'h0, rx_en0[3]}, 8'h00);
    rx_dis[3] = 1'b0;
    tick(RX_DIS);    chk("R3 on not early", {7'h0, rx_en0[3]}, 8'h00);
    tick(1);         chk("R3 on on time", {7'h0, rx_en0[3]}, 8'h01);

    // R4 exact timing, lane 2, both modes
    tx_low[2] = 1'b1;
    tick(TX_SQ);     chk("R4 not early", {6'h0, mute0[2], tx_en1[2]}, 8'h01);
    tick(1);         chk("R4 on time", {6'h0, mute0[2], tx_en1[2]}, 8'h02);

    // R7 clear while condition still present keeps the flag
    clr[2] = 1'b1; tick(1); clr[2] = 1'b0; tick(1);
    chk("R7 clear ignored while present", {6'h0, flag1[2], flag0[2]}, 8'h03);
    tx_low = '0; tick(SETTLE);
    clr = '1; tick(1); clr = '0; tick(1);

    // R6 exact timing, lane 0, asymmetric off/on windows
    tx_sqd[0] = 1'b1; tick(SETTLE);
    tx_dis[0] = 1'b1;
    tick(TX_OFF);    chk("R6 off not early", {6'h0, tx_en1[0], tx_en0[0]}, 8'h03);
    tick(1);         chk("R6 off on time", {6'h0, tx_en1[0], tx_en0[0]}, 8'h00);
    tx_dis[0] = 1'b0;
    tick(TX_ON);     chk("R6 on not early", {6'h0, tx_en1[0], tx_en0[0]}, 8'h00);
    tick(1);         chk("R6 on on time", {6'h0, tx_en1[0], tx_en0[0]}, 8'h03);
    tx_sqd = '0; tick(SETTLE);

    // R9 short pulses filtered
    rx_los[2] = 1'b1; tx_low[1] = 1'b1; rx_dis[0] = 1'b1;
    tick(RX_SQ - 1);
    rx_los[2] = 1'b0; rx_dis[0] = 1'b0;
    tick(TX_SQ - RX_SQ);
    tx_low[1] = 1'b0;
    for (int k = 0; k < 10; k++) begin
      chk("R9 glitch rx", {4'h0, rx_en0}, 8'h0F);
      chk("R9 glitch tx", {mute0, tx_en1}, 8'h0F);
      chk("R9 glitch flag", {flag1, flag0}, 8'h00);
      tick(1);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule